// File: doc/BRIEF.md
# Master/Slave Synchronous Serial Controller

This block is an 8-bit synchronous serial port for a host processor. It can run as a master, making its own serial clock from the system clock. It can also run as a slave, taking the serial clock and an active-low select from outside. Clock polarity and clock phase are both programmable. Every transfer moves eight bits, most significant bit first. The outgoing byte is shifted out while the incoming byte is shifted into the same register.

The host reaches the block through a small register port with four locations:

- control
- divider
- data (write loads the shift register, read returns the receive buffer)
- status

A sticky completion flag drives the interrupt output when interrupts are enabled.

In master mode the data line goes back to logic 1 after a frame, so an asynchronous receiver can listen to it. In slave mode the data line is released unless transmit is enabled. One output reports when the serial pins are in use, so that the pads can go back to general-purpose I/O when the block is switched off.

Top module: `sync_serial_port`

## Requirements
- R1: After reset all four registers read 0. Address 0 is the control register, with bit 0 enable, bit 1 master, bit 2 clock polarity, bit 3 clock phase, bit 4 transmit enable and bit 5 interrupt enable. Address 1 is the divider N. Address 2 is data: a write loads the shift register and a read returns the receive buffer. Address 3 is status, with bit 0 the completion flag. The control and divider registers read back what was written.
- R2: In master mode, a data write while idle starts a transfer. The serial clock then makes exactly 16 transitions, spaced N+1 system clocks apart, the first one N+1 clocks after the write. Between transfers the serial clock rests at the polarity bit.
- R3: Data leaves MSB first. With phase 0, a bit is valid before the leading clock transition and changes on the trailing one. With phase 1, a bit changes on the leading transition and is sampled on the trailing one.
- R4: On the 16th transition the received byte is copied to the receive buffer and the completion flag is set.
- R5: In master mode, after the 16th transition the data output keeps the last bit for 2·(N+1) more system clocks and then drives 1. It also drives 1 whenever the master is idle.
- R6: A data write while a master transfer is running is ignored.
- R7: The completion flag stays set until the host writes 1 to bit 0 of status. The interrupt output is high exactly while the flag and the interrupt enable bit are both 1.
- R8: In slave mode the serial clock, select and data input each pass through two synchronizing flip-flops. Shifting happens only while select is low. Clock transitions while select is high leave the shift register untouched. After 16 transitions the received byte reaches the receive buffer and the flag is set.
- R9: In slave mode the data output is enabled only while the block is enabled, transmit enable is 1 and select is low. When enabled, it presents the loaded byte MSB first.
- R10: If select goes high partway through a slave frame, the frame is dropped without setting the flag. The next frame starts again from bit 7.
- R11: Clearing the enable bit aborts any transfer at once. It sets the pins-active output low and disables both output enables. Data writes made while disabled are ignored.
- R12: The serial clock output enable equals enable AND master. The master data output enable is high whenever the block is enabled in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| pins_active | output | 1 | Serial pins are claimed by the block |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_in | input | 1 | Serial clock received in slave mode |
| ss_n | input | 1 | Active-low slave select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The bench uses the default widths: an 8-bit frame and an 8-bit divider. It programs divider values from 0 to 3, so a whole master frame, including its trailing hold, completes within 72 system clocks. This makes every polarity and phase combination, a write during a running transfer and a mid-frame disable cheap to cover with a per-cycle reference. In slave mode the bench drives the serial clock with a half period of eight system clocks, well inside the rate the synchronizers allow. It also exercises frames that are aborted by the select line and clock activity while the slave is deselected.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              pins_active,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sclk_in,
  input  logic              ss_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);

  typedef enum logic [1:0] {IDLE = 2'd0, RUN = 2'd1, HOLD = 2'd2} mstate_t;

  logic en_q, master_q, cpol_q, cpha_q, txen_q, ie_q;
  logic [DIV_W-1:0]  div_q, div_cnt;
  logic [DATA_W-1:0] shreg, rxbuf;
  logic [CNT_W-1:0]  edge_cnt;
  logic              done_q, out_bit, sclk_q, hold_half;
  mstate_t           state;
  logic [1:0]        sclk_s, ss_s, sdi_s;
  logic              sclk_d, ss_d;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_div  = reg_wr && reg_addr == A_DIV;
  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire wr_stat = reg_wr && reg_addr == A_STAT;

  wire ss_act  = ~ss_s[1];
  wire tick    = div_cnt == div_q;
  wire m_edge  = en_q && master_q && state == RUN && tick;
  wire s_edge  = en_q && !master_q && ss_act && (sclk_s[1] ^ sclk_d);
  wire sh_edge = m_edge || s_edge;
  wire lead    = master_q ? (sclk_q == cpol_q) : (sclk_s[1] != cpol_q);
  wire sample  = lead ^ cpha_q;
  wire last    = edge_cnt == LAST;
  wire rx_bit  = master_q ? sdi : sdi_s[1];
  wire [DATA_W-1:0] shreg_nx = {shreg[DATA_W-2:0], rx_bit};
  wire skip_launch = master_q && !cpha_q && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie_q, txen_q, cpha_q, cpol_q, master_q, en_q} <= '0;
      div_q     <= '0;
      div_cnt   <= '0;
      shreg     <= '0;
      rxbuf     <= '0;
      edge_cnt  <= '0;
      done_q    <= 1'b0;
      out_bit   <= 1'b0;
      sclk_q    <= 1'b0;
      hold_half <= 1'b0;
      state     <= IDLE;
      sclk_s    <= '0;
      ss_s      <= 2'b11;
      sdi_s     <= '0;
      sclk_d    <= 1'b0;
      ss_d      <= 1'b0;
    end else begin
      sclk_s <= {sclk_s[0], sclk_in};
      ss_s   <= {ss_s[0], ss_n};
      sdi_s  <= {sdi_s[0], sdi};
      sclk_d <= sclk_s[1];
      ss_d   <= ss_act;

      if (wr_ctrl) {ie_q, txen_q, cpha_q, cpol_q, master_q, en_q} <= reg_wdata[5:0];
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      if (wr_stat && reg_wdata[0]) done_q <= 1'b0;

      if (!en_q) begin
        state     <= IDLE;
        edge_cnt  <= '0;
        div_cnt   <= '0;
        hold_half <= 1'b0;
      end else if (master_q) begin
        case (state)
          IDLE: if (wr_data) begin
            shreg    <= reg_wdata;
            out_bit  <= reg_wdata[DATA_W-1];
            sclk_q   <= cpol_q;
            div_cnt  <= '0;
            edge_cnt <= '0;
            state    <= RUN;
          end
          RUN: begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
              sclk_q <= ~sclk_q;
              if (last) begin
                state     <= HOLD;
                hold_half <= 1'b0;
              end
            end
          end
          HOLD: begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) begin
              if (hold_half) state <= IDLE;
              hold_half <= 1'b1;
            end
          end
          default: state <= IDLE;
        endcase
      end else begin
        state <= IDLE;
        if (!ss_act) begin
          edge_cnt <= '0;
        end else if (!ss_d) begin
          out_bit  <= shreg[DATA_W-1];
          edge_cnt <= '0;
        end
        if (wr_data && (!ss_act || edge_cnt == '0)) begin
          shreg   <= reg_wdata;
          out_bit <= reg_wdata[DATA_W-1];
        end
      end

      if (sh_edge) begin
        edge_cnt <= last ? '0 : edge_cnt + 1'b1;
        if (sample) shreg <= shreg_nx;
        if (!sample && !skip_launch) out_bit <= shreg[DATA_W-1];
        if (last) begin
          rxbuf  <= sample ? shreg_nx : shreg;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DATA_W-6){1'b0}}, ie_q, txen_q, cpha_q, cpol_q, master_q, en_q};
      A_DIV:   reg_rdata = DATA_W'(div_q);
      A_DATA:  reg_rdata = rxbuf;
      default: reg_rdata = {{(DATA_W-1){1'b0}}, done_q};
    endcase
  end

  wire m_idle = !en_q || state == IDLE;

  assign irq         = done_q & ie_q;
  assign pins_active = en_q;
  assign sclk_oe     = en_q & master_q;
  assign sclk_out    = m_idle ? cpol_q : sclk_q;
  assign sdo         = master_q ? (m_idle ? 1'b1 : out_bit) : out_bit;
  assign sdo_oe      = en_q & (master_q | (txen_q & ss_act));
endmodule

module sync_serial_port_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             master_q,
  input logic             done_q,
  input logic             clr_req,
  input logic             wr_data,
  input logic             wr_ctrl,
  input logic             ss_act,
  input logic [1:0]       state,
  input logic [CNT_W-1:0] edge_cnt,
  input logic [7:0]       shreg,
  input logic             sclk_out
);
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_req) |=> done_q); // R7
  AST_IDLE_CLOCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && master_q && state == 2'd0 && !wr_data && !wr_ctrl) |=> $stable(sclk_out)); // R2
  AST_SLAVE_SHREG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_q && !ss_act && !wr_data) |=> $stable(shreg)); // R8
  AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !master_q && !ss_act) |=> edge_cnt == '0); // R10
  AST_DISABLE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (state == 2'd0 && edge_cnt == '0)); // R11
endmodule

bind sync_serial_port sync_serial_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .master_q(master_q), .done_q(done_q),
  .clr_req(wr_stat && reg_wdata[0]), .wr_data(wr_data), .wr_ctrl(wr_ctrl),
  .ss_act(ss_act), .state(state), .edge_cnt(edge_cnt), .shreg(shreg[7:0]),
  .sclk_out(sclk_out)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, pins_active, sclk_out, sclk_oe, sdo, sdo_oe;
  logic sclk_in = 1'b0;
  logic ss_n = 1'b1;
  logic sdi = 1'b0;

  always #4 clk = ~clk;

  sync_serial_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .pins_active(pins_active), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sclk_in(sclk_in), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  int nchecks = 0;
  int nerr = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of the master side, advanced on every rising clock
  int  n_m = 0;
  bit  en_m, ms_m, cpol_m, cpha_m, ie_m;
  logic [7:0] tx_m = '0;
  int  mt = -1;
  bit  mdone = 0;
  bit  model_on = 0;
  wire clr_w = reg_wr && reg_addr == 2'd3 && reg_wdata[0];

  always @(posedge clk) begin
    if (!rst_n) begin
      mt = -1; mdone = 0; n_m = 0;
      {ie_m, cpha_m, cpol_m, ms_m, en_m} = '0;
    end else begin
      if (mt >= 0 && mt + 1 == 16 * (n_m + 1)) mdone = 1;
      else if (clr_w) mdone = 0;
      if (mt >= 0) mt = (mt + 1 >= 18 * (n_m + 1)) ? -1 : mt + 1;
      if (reg_wr && reg_addr == 2'd2 && en_m && ms_m && mt < 0) begin
        mt = 0;
        tx_m = reg_wdata;
      end
      if (reg_wr && reg_addr == 2'd1) n_m = reg_wdata;
      if (reg_wr && reg_addr == 2'd0) begin
        en_m = reg_wdata[0]; ms_m = reg_wdata[1]; cpol_m = reg_wdata[2];
        cpha_m = reg_wdata[3]; ie_m = reg_wdata[5];
        if (!reg_wdata[0]) mt = -1;
      end
    end
  end

  int e_m, idx_m;
  bit sclk_x, sdo_x;
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      e_m = (mt < 0) ? 0 : mt / (n_m + 1);
      if (e_m > 16) e_m = 16;
      sclk_x = (mt < 0) ? cpol_m : (cpol_m ^ e_m[0]);
      if (mt < 0) sdo_x = 1'b1;
      else if (e_m >= 16) sdo_x = tx_m[0];
      else begin
        idx_m = cpha_m ? ((e_m == 0) ? 0 : (e_m - 1) / 2) : e_m / 2;
        if (idx_m > 7) idx_m = 7;
        sdo_x = tx_m[7 - idx_m];
      end
      chk(pins_active == en_m, "R11 pins_active", pins_active, en_m);
      chk(sclk_oe == (en_m & ms_m), "R12 sclk_oe", sclk_oe, en_m & ms_m);
      chk(irq == (mdone & ie_m), "R7 irq", irq, mdone & ie_m);
      if (en_m && ms_m) begin
        chk(sdo_oe == 1'b1, "R12 master sdo_oe", sdo_oe, 1);
        chk(sclk_out == sclk_x, "R2 sclk_out", sclk_out, sclk_x);
        chk(sdo == sdo_x, (mt >= 16 * (n_m + 1) || mt < 0) ? "R5 sdo hold/idle" : "R3 sdo bit",
            sdo, sdo_x);
      end else begin
        chk(sdo_oe == 1'b0 || !en_m, "R11 sdo_oe off", sdo_oe, 0);
      end
    end
  end

  // external slave responder for master transfers
  bit drv_on = 0;
  bit prev_s = 0;
  int jcnt = 0;
  logic [7:0] rx_pat = '0;
  always @(negedge clk) begin
    if (drv_on && sclk_out !== prev_s) begin
      if ((jcnt % 2 == 0) == (cpha_m == 1'b0)) begin
        if (jcnt / 2 < 7) sdi = rx_pat[6 - jcnt / 2];
      end
      jcnt++;
    end
    prev_s = sclk_out;
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic master_run(input logic [7:0] tx, input logic [7:0] rx, input int n,
                            input bit cpol, input bit cpha, input bit poke);
    logic [7:0] v;
    wr(2'd1, 8'(n));
    wr(2'd0, {2'b10, cpha, cpol, 2'b11});
    rx_pat = rx; sdi = rx[7]; jcnt = 0; prev_s = cpol; drv_on = 1;
    wr(2'd2, tx);
    if (poke) begin
      repeat (3) @(negedge clk);
      wr(2'd2, ~tx); // R6 ignored while busy
    end
    repeat (18 * (n + 1) + 4) @(negedge clk);
    drv_on = 0;
    rd(2'd2, v); chk(v == rx, "R4 receive buffer", v, rx);
    rd(2'd3, v); chk(v == 8'h01, "R4 done flag set", v, 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v == 8'h01, "R7 flag sticky", v, 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk(v == 8'h00, "R7 flag cleared", v, 0);
  endtask

  bit s_cpol, s_cpha;
  task automatic slave_xfer(input logic [7:0] pat, input int nb,
                            output logic [7:0] got, output bit oe_any);
    got = '0; oe_any = 0;
    @(negedge clk); ss_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      if (!s_cpha) begin
        sdi = pat[7 - b];
        repeat (8) @(negedge clk);
        got[7 - b] = sdo; oe_any |= sdo_oe;
        sclk_in = ~s_cpol;
        repeat (8) @(negedge clk);
        sclk_in = s_cpol;
      end else begin
        sclk_in = ~s_cpol;
        sdi = pat[7 - b];
        repeat (8) @(negedge clk);
        got[7 - b] = sdo; oe_any |= sdo_oe;
        sclk_in = s_cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic slave_cfg(input bit cpol, input bit cpha, input bit txen);
    s_cpol = cpol; s_cpha = cpha;
    sclk_in = cpol;
    wr(2'd0, {2'b00, txen, cpha, cpol, 2'b01});
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, got;
    bit oe_any;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk(v == 8'h00, "R1 reset value", v, 0);
    end
    chk(pins_active == 0 && sclk_oe == 0 && sdo_oe == 0 && irq == 0, "R1 reset outputs",
        {pins_active, sclk_oe, sdo_oe, irq}, 0);
    wr(2'd1, 8'h05); rd(2'd1, v); chk(v == 8'h05, "R1 divider readback", v, 5);
    wr(2'd0, 8'h2B); rd(2'd0, v); chk(v == 8'h2B, "R1 control readback", v, 8'h2B);

    model_on = 1;
    master_run(8'hA5, 8'h3C, 0, 0, 0, 0);
    master_run(8'h96, 8'hE1, 2, 1, 1, 0);
    master_run(8'h0F, 8'h81, 1, 0, 1, 1);
    master_run(8'hC3, 8'h5A, 3, 1, 0, 1);

    // R11 mid-transfer disable
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h23);
    wr(2'd2, 8'h77);
    repeat (12) @(negedge clk);
    wr(2'd0, 8'h22);
    chk(pins_active == 0 && sclk_oe == 0 && sdo_oe == 0, "R11 pins released",
        {pins_active, sclk_oe, sdo_oe}, 0);
    repeat (60) @(negedge clk);
    rd(2'd3, v); chk(v == 8'h00, "R11 aborted frame no flag", v, 0);
    rd(2'd2, v); chk(v == 8'h5A, "R11 receive buffer kept", v, 8'h5A);
    wr(2'd2, 8'h11); // ignored while disabled
    wr(2'd0, 8'h23);
    repeat (20) @(negedge clk);
    chk(sdo == 1'b1, "R11 disabled write ignored", sdo, 1);
    model_on = 0;

    // slave, phase 0, polarity 1, transmit on
    slave_cfg(1, 0, 1);
    chk(sclk_oe == 0 && pins_active == 1, "R12 slave clock not driven", {sclk_oe, pins_active}, 1);
    wr(2'd2, 8'hB4);
    for (int k = 0; k < 16; k++) begin
      sclk_in = ~sclk_in; sdi = k[0];
      repeat (4) @(negedge clk);
    end
    sclk_in = s_cpol;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 0, "R9 deselected output off", sdo_oe, 0);
    rd(2'd3, v); chk(v == 8'h00, "R8 no shift while deselected", v, 0);
    slave_xfer(8'h6D, 8, got, oe_any);
    chk(got == 8'hB4, "R8 shreg untouched while deselected", got, 8'hB4);
    chk(oe_any == 1, "R9 output enabled when selected", oe_any, 1);
    rd(2'd2, v); chk(v == 8'h6D, "R8 slave receive", v, 8'h6D);
    rd(2'd3, v); chk(v == 8'h01, "R8 slave flag", v, 1);
    wr(2'd3, 8'h01);

    // slave, phase 1, polarity 0, transmit on
    slave_cfg(0, 1, 1);
    wr(2'd2, 8'h39);
    slave_xfer(8'hD2, 8, got, oe_any);
    chk(got == 8'h39, "R9 slave transmit MSB first", got, 8'h39);
    rd(2'd2, v); chk(v == 8'hD2, "R3 slave phase 1 receive", v, 8'hD2);
    wr(2'd3, 8'h01);

    // slave, transmit off
    slave_cfg(0, 0, 0);
    slave_xfer(8'h4E, 8, got, oe_any);
    chk(oe_any == 0, "R9 transmit disabled stays released", oe_any, 0);
    rd(2'd2, v); chk(v == 8'h4E, "R8 receive with transmit off", v, 8'h4E);
    wr(2'd3, 8'h01);

    // R10 abort by select
    slave_cfg(1, 1, 1);
    slave_xfer(8'hF0, 3, got, oe_any);
    rd(2'd3, v); chk(v == 8'h00, "R10 aborted frame no flag", v, 0);
    rd(2'd2, v); chk(v == 8'h4E, "R10 buffer unchanged", v, 8'h4E);
    slave_xfer(8'h2B, 8, got, oe_any);
    rd(2'd2, v); chk(v == 8'h2B, "R10 next frame realigned", v, 8'h2B);
    rd(2'd3, v); chk(v == 8'h01, "R10 next frame flag", v, 1);

    finish_run();
  end
endmodule